// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode Stage

This stage sits in front of a byte-addressed, dual-ported program memory. It holds the program counter, presents it on the instruction port, and takes back the 32-bit little-endian word whose lowest byte sits at that address. From the first byte it works out how long the instruction is, one to four bytes. It then splits out the stack-control byte and the immediate bytes. Once the downstream stage accepts the instruction, the counter moves past it. Instructions may start at any byte address.

Literal-load instructions take their constant from the second memory port. While such an instruction is presented, the stage requests a read at the first byte after the instruction. It sign-extends the 8- or 16-bit result to 32 bits, or passes a 32-bit result through unchanged. On acceptance the counter skips both the instruction and its literal bytes. A taken branch or jump supplies a new target. The word fetched in that cycle is then marked invalid, and the counter loads the target on the next edge.

Top module: `vlf_fetch`

## Requirements
- R1: After reset the program counter equals RESET_PC (0 by default), and with no redirect pending `out_valid` is 1 and `out_pc` shows that address.
- R2: `out_len` = opcode[7:6] + 1, where the opcode is `imem_word[7:0]`.
- R3: For a length of 2 or more, `out_sel_a` = word[10:8], `out_pop_a` = word[11], `out_sel_b` = word[14:12] and `out_pop_b` = word[15]. For a length of 1 all four are 0.
- R4: `out_imm` is {8'h00, word[23:16]} for length 3, word[31:16] for length 4, and 0 for length 1 or 2.
- R5: When a non-literal instruction is accepted (`out_valid` and `out_ready`, no redirect), the counter advances by `out_len`, modulo 2^ADDR_W.
- R6: An opcode with bits [5:3] = 3'b111 is a literal load, and bits [1:0] give its size: 00 is 1 byte, 01 is 2 bytes, 10 and 11 are 4 bytes. While it is valid, `dmem_req` = 1, `dmem_addr` = PC + `out_len` and `dmem_size` = opcode[1:0]. On acceptance the counter advances by `out_len` plus the literal size. For every other opcode `dmem_req` = 0.
- R7: `out_lit` is `dmem_rdata[7:0]` sign-extended for size 00, `dmem_rdata[15:0]` sign-extended for size 01, and all of `dmem_rdata` for sizes 10 and 11. It is 0 for non-literal opcodes.
- R8: While `out_valid` is 1 and `out_ready` is 0, the counter and the presented instruction stay unchanged.
- R9: In a cycle with `redirect_en` = 1, `out_valid` and `dmem_req` are 0 whatever the state of `out_ready`, and on the next edge the counter loads `redirect_pc`.
- R10: Instructions are decoded correctly at every byte address, including ones whose bytes wrap past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | ADDR_W | Instruction port byte address (current PC) |
| imem_word | input | 32 | Four bytes starting at `imem_addr`, lowest address in [7:0] |
| redirect_en | input | 1 | Taken branch or jump this cycle |
| redirect_pc | input | ADDR_W | Branch or jump target |
| out_ready | input | 1 | Downstream stage accepts the instruction |
| out_valid | output | 1 | Presented instruction is valid |
| out_pc | output | ADDR_W | Address of the presented instruction |
| out_opcode | output | 8 | Opcode byte |
| out_len | output | 3 | Instruction length in bytes, 1 to 4 |
| out_sel_a | output | 3 | Stack A select |
| out_pop_a | output | 1 | Stack A pop flag |
| out_sel_b | output | 3 | Stack B select |
| out_pop_b | output | 1 | Stack B pop flag |
| out_imm | output | 16 | Immediate bytes, zero where absent |
| dmem_req | output | 1 | Literal read request on the data port |
| dmem_addr | output | ADDR_W | Literal byte address |
| dmem_size | output | 2 | Literal size code |
| dmem_rdata | input | 32 | Data returned from `dmem_addr`, lowest address in [7:0] |
| out_lit | output | 32 | Sign-extended literal value |

## Verification
The hardest case to reach from the ports is an instruction or literal that straddles the top of the address space, because it means placing every opcode at an arbitrary byte address. The bench reaches it by redirecting to a fresh address for each of the 256 opcodes, taken as opcode × 7 + 3 modulo 256, so every byte address is used exactly once. Each of those cycles holds the ready input high while the redirect is asserted, which also confirms that the redirect takes priority over acceptance. One stall cycle follows before acceptance, and the bench checks that the counter then lands past the instruction and any literal.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OPC_W  = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned LEN_W  = 3;

  typedef enum logic [1:0] {
    LSZ_BYTE  = 2'b00,
    LSZ_HALF  = 2'b01,
    LSZ_WORD  = 2'b10,
    LSZ_WORD2 = 2'b11
  } lit_size_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel_a;
    logic             pop_a;
    logic [SEL_W-1:0] sel_b;
    logic             pop_b;
  } stk_ctl_t;
endpackage

// File: rtl/vlf_decode.sv
module vlf_decode
  import vlf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [LEN_W-1:0]  len,
  output stk_ctl_t          stk,
  output logic [IMM_W-1:0]  imm,
  output logic              is_lit,
  output lit_size_e         lit_size
);
  localparam int unsigned IMM_LANES = IMM_W / 8;

  logic [OPC_W-1:0] opc;
  logic             has_stk;

  always_comb begin
    opc     = word[OPC_W-1:0];
    len     = {1'b0, opc[7:6]} + 3'd1;
    has_stk = (opc[7:6] != 2'b00);
    if (has_stk) begin
      stk.sel_a = word[10:8];
      stk.pop_a = word[11];
      stk.sel_b = word[14:12];
      stk.pop_b = word[15];
    end else begin
      stk = '0;
    end
    is_lit   = (opc[5:3] == 3'b111);
    lit_size = lit_size_e'(opc[1:0]);
  end

  for (genvar ln = 0; ln < IMM_LANES; ln++) begin : g_imm_lane
    always_comb begin
      if (len > LEN_W'(ln + 2))
        imm[8*ln +: 8] = word[16 + 8*ln +: 8];
      else
        imm[8*ln +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/vlf_literal.sv
module vlf_literal
  import vlf_pkg::*;
(
  input  logic              is_lit,
  input  lit_size_e         lit_size,
  input  logic [WORD_W-1:0] rdata,
  output logic [LEN_W-1:0]  nbytes,
  output logic [WORD_W-1:0] value
);
  always_comb begin
    nbytes = '0;
    value  = '0;
    if (is_lit) begin
      unique case (lit_size)
        LSZ_BYTE: begin
          nbytes = 3'd1;
          value  = {{(WORD_W-8){rdata[7]}}, rdata[7:0]};
        end
        LSZ_HALF: begin
          nbytes = 3'd2;
          value  = {{(WORD_W-16){rdata[15]}}, rdata[15:0]};
        end
        default: begin
          nbytes = 3'd4;
          value  = rdata;
        end
      endcase
    end
  end
endmodule

// File: rtl/vlf_pc_reg.sv
module vlf_pc_reg #(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_en,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              fire,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] pc_nxt;
  logic              pc_en;

  always_comb begin
    pc_en = redirect_en | fire;
    if (redirect_en) pc_nxt = redirect_pc;
    else             pc_nxt = pc + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= RESET_PC;
    else if (pc_en) pc <= pc_nxt;
  end

  AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_en && !fire) |=> $stable(pc)); // R8
  AST_ACCEPT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !redirect_en) |=> (pc == $past(pc) + $past(step))); // R5
  AST_REDIRECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_en |=> (pc == $past(redirect_pc))); // R9
endmodule

// File: rtl/vlf_fetch.sv
module vlf_fetch
  import vlf_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [31:0]       imem_word,
  input  logic              redirect_en,
  input  logic [ADDR_W-1:0] redirect_pc,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_pc,
  output logic [7:0]        out_opcode,
  output logic [2:0]        out_len,
  output logic [2:0]        out_sel_a,
  output logic              out_pop_a,
  output logic [2:0]        out_sel_b,
  output logic              out_pop_b,
  output logic [15:0]       out_imm,
  output logic              dmem_req,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [1:0]        dmem_size,
  input  logic [31:0]       dmem_rdata,
  output logic [31:0]       out_lit
);
  localparam int unsigned PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] pc;
  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  lit_nbytes;
  logic [ADDR_W-1:0] step;
  stk_ctl_t          stk;
  logic              is_lit;
  lit_size_e         lit_size;
  logic              fire;

  vlf_decode u_decode (
    .word     (imem_word),
    .len      (len),
    .stk      (stk),
    .imm      (out_imm),
    .is_lit   (is_lit),
    .lit_size (lit_size)
  );

  vlf_literal u_literal (
    .is_lit   (is_lit),
    .lit_size (lit_size),
    .rdata    (dmem_rdata),
    .nbytes   (lit_nbytes),
    .value    (out_lit)
  );

  always_comb begin
    out_valid  = ~redirect_en;
    fire       = out_valid & out_ready;
    step       = {{PAD_W{1'b0}}, len} + {{PAD_W{1'b0}}, lit_nbytes};
    imem_addr  = pc;
    out_pc     = pc;
    out_opcode = imem_word[7:0];
    out_len    = len;
    out_sel_a  = stk.sel_a;
    out_pop_a  = stk.pop_a;
    out_sel_b  = stk.sel_b;
    out_pop_b  = stk.pop_b;
    dmem_req   = out_valid & is_lit;
    dmem_addr  = pc + {{PAD_W{1'b0}}, len};
    dmem_size  = lit_size;
  end

  vlf_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .redirect_en (redirect_en),
    .redirect_pc (redirect_pc),
    .fire        (fire),
    .step        (step),
    .pc          (pc)
  );

  AST_REDIRECT_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_en |-> (!out_valid && !dmem_req)); // R9
  AST_SHORT_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_len == 3'd1) |-> ({out_sel_a, out_pop_a, out_sel_b, out_pop_b} == 8'h00)); // R3
  AST_SHORT_NO_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_len <= 3'd2) |-> (out_imm == 16'h0000)); // R4
  AST_BYTE_LIT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_req && dmem_size == 2'b00) |-> (out_lit[31:8] == {24{out_lit[7]}})); // R7
  AST_NO_REQ_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_opcode[5:3] != 3'b111) |-> (!dmem_req && out_lit == 32'h0)); // R6
endmodule

// File: tb/sim_vlf_fetch.sv
module sim_vlf_fetch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  imem_addr;
  logic [31:0] imem_word;
  logic        redirect_en;
  logic [7:0]  redirect_pc;
  logic        out_ready;
  logic        out_valid;
  logic [7:0]  out_pc;
  logic [7:0]  out_opcode;
  logic [2:0]  out_len;
  logic [2:0]  out_sel_a;
  logic        out_pop_a;
  logic [2:0]  out_sel_b;
  logic        out_pop_b;
  logic [15:0] out_imm;
  logic        dmem_req;
  logic [7:0]  dmem_addr;
  logic [1:0]  dmem_size;
  logic [31:0] dmem_rdata;
  logic [31:0] out_lit;

  logic [7:0] mem [256];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign imem_word  = {mem[imem_addr + 8'd3], mem[imem_addr + 8'd2],
                       mem[imem_addr + 8'd1], mem[imem_addr]};
  assign dmem_rdata = {mem[dmem_addr + 8'd3], mem[dmem_addr + 8'd2],
                       mem[dmem_addr + 8'd1], mem[dmem_addr]};

  vlf_fetch #(.ADDR_W(8), .RESET_PC(8'h00)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_word(imem_word),
    .redirect_en(redirect_en), .redirect_pc(redirect_pc), .out_ready(out_ready),
    .out_valid(out_valid), .out_pc(out_pc), .out_opcode(out_opcode),
    .out_len(out_len), .out_sel_a(out_sel_a), .out_pop_a(out_pop_a),
    .out_sel_b(out_sel_b), .out_pop_b(out_pop_b), .out_imm(out_imm),
    .dmem_req(dmem_req), .dmem_addr(dmem_addr), .dmem_size(dmem_size),
    .dmem_rdata(dmem_rdata), .out_lit(out_lit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; redirect_en = 1'b0; redirect_pc = 8'h00; out_ready = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset pc", 32'(out_pc), 32'h0);
    chk("R1 reset valid", 32'(out_valid), 32'h1);

    for (int op = 0; op < 256; op++) begin
      logic [7:0]  a, b1, d, nxt;
      logic [2:0]  len, nb;
      logic        lit;
      logic [15:0] imm;
      logic [31:0] rd, lv;
      @(negedge clk);
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + op * 11 + 5);
      a = 8'(op * 7 + 3);
      mem[a] = 8'(op);
      redirect_en = 1'b1; redirect_pc = a; out_ready = 1'b1;
      #1;
      chk("R9 valid low on redirect", 32'(out_valid), 32'h0);
      chk("R9 no literal req on redirect", 32'(dmem_req), 32'h0);

      @(negedge clk);
      redirect_en = 1'b0; out_ready = 1'b0;
      #1;
      b1  = mem[a + 8'd1];
      len = 3'(op[7:6]) + 3'd1;
      imm = (len == 3'd3) ? {8'h00, mem[a + 8'd2]} :
            (len == 3'd4) ? {mem[a + 8'd3], mem[a + 8'd2]} : 16'h0;
      lit = (op[5:3] == 3'b111);
      nb  = !lit ? 3'd0 : (op[1:0] == 2'b00) ? 3'd1 : (op[1:0] == 2'b01) ? 3'd2 : 3'd4;
      d   = a + 8'(len);
      rd  = {mem[d + 8'd3], mem[d + 8'd2], mem[d + 8'd1], mem[d]};
      lv  = !lit ? 32'h0 :
            (op[1:0] == 2'b00) ? {{24{rd[7]}}, rd[7:0]} :
            (op[1:0] == 2'b01) ? {{16{rd[15]}}, rd[15:0]} : rd;
      nxt = a + 8'(len) + 8'(nb);
      chk("R9 pc loaded from target", 32'(out_pc), 32'(a));
      chk("R10 opcode at byte address", 32'(out_opcode), 32'(op));
      chk("R2 length", 32'(out_len), 32'(len));
      chk("R3 stack fields", {24'h0, out_sel_a, out_pop_a, out_sel_b, out_pop_b},
          (len >= 3'd2) ? {24'h0, b1[2:0], b1[3], b1[6:4], b1[7]} : 32'h0);
      chk("R4 immediate", 32'(out_imm), 32'(imm));
      chk("R6 literal request", 32'(dmem_req), 32'(lit));
      if (lit) begin
        chk("R6 literal address", 32'(dmem_addr), 32'(d));
        chk("R6 literal size", 32'(dmem_size), 32'(op[1:0]));
      end
      chk("R7 literal value", out_lit, lv);

      @(negedge clk); #1;
      chk("R8 pc held under stall", 32'(out_pc), 32'(a));
      chk("R8 valid under stall", 32'(out_valid), 32'h1);
      out_ready = 1'b1;
      @(negedge clk); #1;
      chk(lit ? "R6 pc skips literal" : "R5 pc advance", 32'(out_pc), 32'(nxt));
      out_ready = 1'b0;
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule